// File: doc/BRIEF.md
# Interleaved Block-Skip DMA Address Generator

This block drives a write port for a strided copy. After a start pulse it walks a contiguous source region one quadword (128 bits) at a time. It writes each quadword to a destination that moves forward in blocks. Within a block the destination advances one quadword per accepted write. At the end of each block it also jumps over a programmable gap of quadwords. The transfer repeats until the total quadword count reaches zero, and a one-cycle done pulse marks the end. A block size of zero means the whole transfer is one block.

A mode bit picks the destination type: plain memory, or a ring buffer described by a base address and a byte mask. In ring mode every destination update is folded back into the ring as `base + (address & mask)`, and each accepted quadword increments a ring transfer counter. The quadword data is read combinationally by the surrounding logic at the current source address and passes straight through to the write port.

Top module: `idma_interleave`

## Requirements
- R1: After reset the block is idle: `wrValid`, `busy` and `done` are 0 and `remaining` is 0.
- R2: A start pulse while idle latches all parameters. From the next cycle `wrValid` is 1, `srcAddr`/`wrAddr` equal the given start addresses and `remaining` equals the total count.
- R3: A block size of 0 is treated as equal to the total count, so the gap is applied only once, after the last quadword.
- R4: Each block moves the smaller of the block size and the quadwords still remaining, so a final short block is allowed.
- R5: `srcAddr` advances by 16 bytes on every accepted write, with no gaps.
- R6: Within a block `wrAddr` advances by 16 per accepted write. At the last quadword of a block it advances by 16 × (1 + gap).
- R7: A gap of 0 gives a fully contiguous destination.
- R8: With `ringMode` = 1, every destination update becomes `ringBase + (next & ringMask)`. `ringXfer` is cleared at start and counts accepted writes in ring mode only.
- R9: `remaining` drops by one per accepted write and reads 0 when the transfer ends. `wrValid` is never 1 with `remaining` = 0.
- R10: `done` is high for exactly one cycle, in the cycle after the last accepted write, and `busy` is already low in that cycle.
- R11: A start pulse while busy is ignored.
- R12: While `wrValid` = 1 and `wrReady` = 0, the addresses and `remaining` hold. `wrData` always equals `rdData`.
- R13: A start with a total count of 0 produces no write and a done pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse (ignored while busy) |
| totalQwc | input | CNT_W | Total quadwords to move |
| blockQwc | input | CNT_W | Quadwords per block, 0 = whole count |
| skipQwc | input | CNT_W | Destination gap in quadwords after each block |
| srcStart | input | ADDR_W | First source byte address |
| dstStart | input | ADDR_W | First destination byte address |
| ringMode | input | 1 | 1 = ring-buffer destination, 0 = plain memory |
| ringBase | input | ADDR_W | Ring base address |
| ringMask | input | ADDR_W | Ring offset mask (bytes) |
| rdData | input | DATA_W | Quadword read at `srcAddr` |
| wrValid | output | 1 | Write request valid |
| wrReady | input | 1 | Write accepted when high with `wrValid` |
| wrData | output | DATA_W | Write data |
| wrAddr | output | ADDR_W | Current destination address |
| srcAddr | output | ADDR_W | Current source address |
| remaining | output | CNT_W | Quadwords still to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| ringXfer | output | CNT_W | Quadwords written in ring mode since start |

## Verification
The main stride logic is run with three block/gap shapes:
- An uneven split (10 quadwords in blocks of 4 with a gap of 2) separates the per-block minimum from a fixed block length.
- A zero block size with a nonzero gap shows whether the gap is wrongly applied inside the single block.
- A zero gap shows that the boundary jump then collapses to a plain increment.

A ring run starting near the top of a small ring checks the fold on both the inner increment and the gap jump. A run with periodic backpressure checks that stalls freeze every address. A start pulse injected mid-run, a zero-length start and a block larger than the total cover the remaining edge cases.

// File: rtl/idma_pkg.sv
package idma_pkg;
  // Strobes from the control half to the address datapath
  typedef struct packed {
    logic load;      // latch parameters, new transfer
    logic step;      // one quadword accepted by the write port
    logic blockEnd;  // accepted quadword closes its block
  } dmaStrobe_t;
endpackage

// File: rtl/idma_ctrl.sv
module idma_ctrl
  import idma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] totalQwc,
  input  logic [CNT_W-1:0] blockQwc,
  input  logic             wrReady,
  output dmaStrobe_t       stb,
  output logic             wrValid,
  output logic [CNT_W-1:0] remaining,
  output logic             busy,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             busyQ, doneQ;
  logic [CNT_W-1:0] cntQ, blkSizeQ, blkLeftQ;
  logic [CNT_W-1:0] effBlk, cntLess;

  function automatic logic [CNT_W-1:0] minOf(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  assign effBlk       = (blockQwc == '0) ? totalQwc : blockQwc;
  assign cntLess      = cntQ - ONE;
  assign stb.load     = start && !busyQ;
  assign stb.step     = busyQ && wrReady;
  assign stb.blockEnd = stb.step && (blkLeftQ == ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      doneQ    <= 1'b0;
      cntQ     <= '0;
      blkSizeQ <= '0;
      blkLeftQ <= '0;
    end else begin
      doneQ <= 1'b0;
      if (stb.load) begin
        cntQ     <= totalQwc;
        blkSizeQ <= effBlk;
        blkLeftQ <= minOf(effBlk, totalQwc);
        busyQ    <= (totalQwc != '0);
        doneQ    <= (totalQwc == '0);
      end else if (stb.step) begin
        cntQ <= cntLess;
        if (cntQ == ONE) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
        if (stb.blockEnd) blkLeftQ <= minOf(blkSizeQ, cntLess);
        else              blkLeftQ <= blkLeftQ - ONE;
      end
    end
  end

  assign wrValid   = busyQ;
  assign busy      = busyQ;
  assign done      = doneQ;
  assign remaining = cntQ;
endmodule

// File: rtl/idma_datapath.sv
module idma_datapath
  import idma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 128,
  parameter bit RING_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        stb,
  input  logic [CNT_W-1:0]  skipQwc,
  input  logic [ADDR_W-1:0] srcStart,
  input  logic [ADDR_W-1:0] dstStart,
  input  logic              ringMode,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [ADDR_W-1:0] ringMask,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  ringXfer
);
  localparam int QW_BYTES = DATA_W / 8;
  localparam int QW_SHIFT = $clog2(QW_BYTES);
  localparam logic [ADDR_W-1:0] QW_INC = ADDR_W'(QW_BYTES);

  logic [ADDR_W-1:0] srcQ, dstQ, baseQ, maskQ, stepBytes, dstRaw, dstNext;
  logic [CNT_W-1:0]  skipQ;
  logic              ringQ;

  assign stepBytes = stb.blockEnd ? ((ADDR_W'(skipQ) + ADDR_W'(1)) << QW_SHIFT) : QW_INC;
  assign dstRaw    = dstQ + stepBytes;
  assign dstNext   = ringQ ? (baseQ + (dstRaw & maskQ)) : dstRaw;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ  <= '0;
      dstQ  <= '0;
      baseQ <= '0;
      maskQ <= '0;
      skipQ <= '0;
      ringQ <= 1'b0;
    end else if (stb.load) begin
      srcQ  <= srcStart;
      dstQ  <= dstStart;
      baseQ <= ringBase;
      maskQ <= ringMask;
      skipQ <= skipQwc;
      ringQ <= ringMode && RING_EN;
    end else if (stb.step) begin
      srcQ <= srcQ + QW_INC;
      dstQ <= dstNext;
    end
  end

  generate
    if (RING_EN) begin : g_ringCnt
      logic [CNT_W-1:0] ringCntQ;
      always_ff @(posedge clk) begin
        if (!rstN)                    ringCntQ <= '0;
        else if (stb.load)            ringCntQ <= '0;
        else if (stb.step && ringQ)   ringCntQ <= ringCntQ + CNT_W'(1);
      end
      assign ringXfer = ringCntQ;
    end else begin : g_noRing
      assign ringXfer = '0;
    end
  endgenerate

  assign srcAddr = srcQ;
  assign dstAddr = dstQ;
  assign wrData  = rdData;
endmodule

// File: rtl/idma_interleave.sv
module idma_interleave
  import idma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 128,
  parameter bit RING_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  totalQwc,
  input  logic [CNT_W-1:0]  blockQwc,
  input  logic [CNT_W-1:0]  skipQwc,
  input  logic [ADDR_W-1:0] srcStart,
  input  logic [ADDR_W-1:0] dstStart,
  input  logic              ringMode,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [ADDR_W-1:0] ringMask,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [DATA_W-1:0] wrData,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [CNT_W-1:0]  remaining,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  ringXfer
);
  dmaStrobe_t stb;

  idma_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .totalQwc(totalQwc),
    .blockQwc(blockQwc), .wrReady(wrReady), .stb(stb), .wrValid(wrValid),
    .remaining(remaining), .busy(busy), .done(done)
  );

  idma_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .RING_EN(RING_EN)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .skipQwc(skipQwc), .srcStart(srcStart),
    .dstStart(dstStart), .ringMode(ringMode), .ringBase(ringBase), .ringMask(ringMask),
    .rdData(rdData), .srcAddr(srcAddr), .dstAddr(wrAddr), .wrData(wrData),
    .ringXfer(ringXfer)
  );
endmodule

// File: rtl/idma_chk.sv
module idma_chk
  import idma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              wrValid,
  input logic              wrReady,
  input logic [CNT_W-1:0]  remaining,
  input logic [ADDR_W-1:0] srcAddr,
  input logic [ADDR_W-1:0] dstAddr,
  input dmaStrobe_t        stb
);
  localparam logic [ADDR_W-1:0] QW_INC = ADDR_W'(DATA_W / 8);

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |=> remaining == $past(remaining) - CNT_W'(1));

  p_valid_nonzero_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> remaining != '0);

  p_src_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |=> srcAddr == $past(srcAddr) + QW_INC);

  p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> ($stable(srcAddr) && $stable(dstAddr) && $stable(remaining)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_busy_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !(wrValid && wrReady)) |=> ($stable(remaining) && $stable(srcAddr) && $stable(dstAddr)));
endmodule

bind idma_interleave idma_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .wrValid(wrValid), .wrReady(wrReady), .remaining(remaining),
  .srcAddr(srcAddr), .dstAddr(wrAddr), .stb(stb)
);

// File: tb/idma_interleave_test.sv
module idma_interleave_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 128;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  totalQwc = '0, blockQwc = '0, skipQwc = '0;
  logic [ADDR_W-1:0] srcStart = '0, dstStart = '0, ringBase = '0, ringMask = '0;
  logic              ringMode = 1'b0;
  logic [DATA_W-1:0] rdData, wrData;
  logic              wrValid, wrReady = 1'b1;
  logic [ADDR_W-1:0] wrAddr, srcAddr;
  logic [CNT_W-1:0]  remaining, ringXfer;
  logic              busy, done;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // external scratch memory model: data derived from address
  assign rdData = {4{srcAddr ^ 32'h5A5A_0000}};

  idma_interleave uut (
    .clk(clk), .rstN(rstN), .start(start), .totalQwc(totalQwc), .blockQwc(blockQwc),
    .skipQwc(skipQwc), .srcStart(srcStart), .dstStart(dstStart), .ringMode(ringMode),
    .ringBase(ringBase), .ringMask(ringMask), .rdData(rdData), .wrValid(wrValid),
    .wrReady(wrReady), .wrData(wrData), .wrAddr(wrAddr), .srcAddr(srcAddr),
    .remaining(remaining), .busy(busy), .done(done), .ringXfer(ringXfer)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Generic run: drives a start, then checks every accepted write against a
  // model built from the requirements. stall=1 drops wrReady every third cycle.
  // poke=1 pulses start with other settings mid-run (must be ignored, R11).
  task automatic runXfer(input string req, input int total, input int blk, input int skip,
                         input logic [31:0] src, input logic [31:0] dst, input bit ring,
                         input logic [31:0] base, input logic [31:0] mask,
                         input bit stall, input bit poke);
    int blkSize, left, rem, accepted, cyc, ringCnt;
    logic [31:0] eSrc, eDst;
    bit doneSeen;
    blkSize = (blk == 0) ? total : blk;
    left = (blkSize < total) ? blkSize : total;
    rem = total; eSrc = src; eDst = dst; accepted = 0; ringCnt = 0; doneSeen = 0;
    @(negedge clk);
    totalQwc = CNT_W'(total); blockQwc = CNT_W'(blk); skipQwc = CNT_W'(skip);
    srcStart = src; dstStart = dst; ringMode = ring; ringBase = base; ringMask = mask;
    start = 1'b1; wrReady = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (cyc = 0; cyc < 2000; cyc++) begin
      wrReady = !stall || (cyc % 3 != 1);
      if (poke) begin
        start = (cyc == 2);
        if (cyc == 2) begin totalQwc = 16'd3; srcStart = 32'hDEAD_0000; dstStart = 32'h0; end
      end
      #1;
      if (done) begin doneSeen = 1; break; end
      if (cyc == 0 && total != 0)
        check(wrValid && remaining == CNT_W'(total), "R2", "first cycle valid/remaining", longint'(remaining), total);
      if (wrValid && wrReady) begin
        check(srcAddr == eSrc, req, "srcAddr", srcAddr, eSrc);
        check(wrAddr == eDst, req, "wrAddr", wrAddr, eDst);
        check(remaining == CNT_W'(rem), "R9", "remaining", remaining, rem);
        check(wrData == {4{eSrc ^ 32'h5A5A_0000}}, "R12", "wrData", wrData[31:0], eSrc ^ 32'h5A5A_0000);
        accepted++; rem--; left--; eSrc = eSrc + 32'd16;
        if (ring) ringCnt++;
        if (left == 0) begin
          eDst = eDst + 32'd16 * (32'(skip) + 32'd1);
          left = (blkSize < rem) ? blkSize : rem;
        end else eDst = eDst + 32'd16;
        if (ring) eDst = base + (eDst & mask);
      end else if (wrValid) begin
        check(srcAddr == eSrc && wrAddr == eDst, "R12", "hold during stall", wrAddr, eDst);
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(doneSeen, "R10", "done seen", doneSeen, 1);
    check(accepted == total, "R4", "writes accepted", accepted, total);
    check(remaining == '0 && !busy, "R9", "remaining zero, idle at done", remaining, 0);
    check(srcAddr == eSrc, req, "final srcAddr", srcAddr, eSrc);
    check(wrAddr == eDst, req, "final wrAddr", wrAddr, eDst);
    check(ringXfer == CNT_W'(ringCnt), "R8", "ringXfer", ringXfer, ringCnt);
    @(negedge clk); #1;
    check(!done && !wrValid, "R10", "done one cycle wide", done, 0);
  endtask

  task automatic testReset;
    check(!wrValid && !busy && !done && remaining == '0, "R1", "reset state",
          {wrValid, busy, done}, 0);
  endtask

  task automatic testUneven;   // R4 R6: blocks 4,4,2 with gap 2
    runXfer("R6", 10, 4, 2, 32'h0000_0100, 32'h0001_0000, 0, 0, 0, 0, 0);
  endtask

  task automatic testZeroBlock; // R3: single block, gap only at the end
    runXfer("R3", 5, 0, 3, 32'h0000_0200, 32'h0002_0000, 0, 0, 0, 0, 0);
  endtask

  task automatic testZeroSkip;  // R7: contiguous destination
    runXfer("R7", 7, 3, 0, 32'h0000_0300, 32'h0003_0000, 0, 0, 0, 0, 0);
  endtask

  task automatic testRing;      // R8: 16-quadword ring at 0x1000, start near top
    runXfer("R8", 6, 2, 1, 32'h0000_0400, 32'h0000_10E0, 1, 32'h0000_1000, 32'h0000_00FF, 0, 0);
  endtask

  task automatic testStall;     // R12 R5: backpressure
    runXfer("R5", 9, 4, 1, 32'h0000_0500, 32'h0004_0000, 0, 0, 0, 1, 0);
  endtask

  task automatic testBusyStart; // R11
    runXfer("R11", 8, 3, 2, 32'h0000_0600, 32'h0005_0000, 0, 0, 0, 0, 1);
  endtask

  task automatic testBigBlock;  // R4: block larger than total
    runXfer("R4", 3, 8, 4, 32'h0000_0700, 32'h0006_0000, 0, 0, 0, 0, 0);
  endtask

  task automatic testZeroTotal; // R13
    runXfer("R13", 0, 2, 1, 32'h0000_0800, 32'h0007_0000, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    miscompares++;
    vectors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    testUneven();
    testZeroBlock();
    testZeroSkip();
    testRing();
    testUneven();   // plain run after ring: R8 counter must read 0
    testStall();
    testBusyStart();
    testBigBlock();
    testZeroTotal();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule